// File: doc/BRIEF.md
# ECC Direct-Compare Cache Tag Matcher

This block decides whether a cache lookup hits without ever decoding the tag held in the tag array. Stored tags are kept as extended Hamming codewords, which correct one bit and detect two. On a lookup the block encodes the incoming tag with the same encoder that produced the stored word. It forms the bitwise difference between the two codewords and counts the differing bits in a tree of saturating adders. The count is then sorted into one of four outcomes: exact hit, hit after correction, uncorrectable fault, or miss.

The write side is part of the block. A combinational encoder turns the tag to be written into the codeword that goes into the tag array, so lookups and writes use one code. The lookup result is registered once, so the outcome for a request made in cycle N is visible after the clock edge that ends cycle N. The valid bit of the entry qualifies the comparison. With the default tag width of 16 bits the codeword is 22 bits, the correct threshold is 1 and the detect threshold is 2.

Top module: `tag_match_ecc`

## Requirements
- R1: `wr_code_o` is the extended Hamming codeword of `wr_tag_i`. Bits 1..21 use Hamming positions. Tag bits 0..15 fill the positions that are not powers of two, in ascending order. Bit 2^b is the XOR of all data positions whose index has bit b set (b = 0..4). Bit 0 makes the XOR of all 22 bits zero.
- R2: Outcomes are registered. A request in one cycle sets the outputs after the next rising edge. A cycle with `req_i` low leaves all four outputs low after the next edge.
- R3: With a valid entry and distance d = 0 between the encoded probe and the stored word, `hit_o` is 1, `corr_hit_o` is 0, and `fault_o` and `miss_o` are 0.
- R4: With a valid entry and 0 < d <= TMAX (1), both `hit_o` and `corr_hit_o` are 1.
- R5: With a valid entry and TMAX < d <= RMAX (d = 2), `fault_o` is 1 and `hit_o` and `miss_o` are 0.
- R6: With a valid entry and d > RMAX, `miss_o` is 1 and no other output is set. This holds for any d from 3 up to all 22 bits.
- R7: With `entry_valid_i` low, a request yields `miss_o` = 1 and `fault_o` = 0, whatever the distance.
- R8: At most one of `hit_o`, `fault_o` and `miss_o` is high at a time. `corr_hit_o` is high only together with `hit_o`.
- R9: While `rst_n` is low, all four outcome outputs are 0, even if requests are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request this cycle |
| entry_valid_i | input | 1 | Valid bit of the stored entry |
| probe_tag_i | input | 16 | Incoming address tag, assumed error-free |
| stored_code_i | input | 22 | Codeword read from the tag array |
| wr_tag_i | input | 16 | Tag to be written |
| wr_code_o | output | 22 | Codeword for the tag array write (combinational) |
| hit_o | output | 1 | Registered: tag matched, exactly or after correction |
| corr_hit_o | output | 1 | Registered: match needed a one-bit correction |
| fault_o | output | 1 | Registered: detectable but uncorrectable error |
| miss_o | output | 1 | Registered: no match or invalid entry |

## Verification
The assertions take three things for granted. The probe tag carries no errors. `req_i` and `entry_valid_i` are stable around each rising edge. Every stored codeword was produced by the same encoder, possibly with bit flips added. The stimulus keeps to these assumptions in the following ways. Inputs change only on the falling edge. Every stored word is built as the clean codeword of a chosen tag XORed with a mask holding a known number of set bits. The only other stored words are unrelated random codewords, whose distance the bench measures with its own popcount. Each distance band is therefore reached on purpose, including every single and double flip position for several tags, so the saturating count can be checked against the exact count.

// File: rtl/tagcmp_pkg.sv
package tagcmp_pkg;

   // true when x is a positive power of two
   function automatic bit is_pow2(input int x);
      return (x > 0) && ((x & (x - 1)) == 0);
   endfunction

   // number of Hamming check bits needed for k data bits
   function automatic int check_bits(input int k);
      int p;
      p = 0;
      while ((1 << p) < (k + p + 1)) p++;
      return p;
   endfunction

   // full extended codeword width: data, check bits, overall parity
   function automatic int codeword_width(input int k);
      return k + check_bits(k) + 1;
   endfunction

   // codeword position holding data bit idx (skips powers of two and 0)
   function automatic int data_slot(input int idx);
      int seen;
      int r;
      seen = 0;
      r    = 0;
      for (int pos = 1; pos <= idx + 64; pos++) begin
         if (!is_pow2(pos)) begin
            if (seen == idx) r = pos;
            seen++;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/tagcmp_encoder.sv
module tagcmp_encoder #(
   parameter int TAG_W = 16,
   parameter int CW_W  = tagcmp_pkg::codeword_width(TAG_W)
) (
   input  logic [TAG_W-1:0] tag_i,
   output logic [CW_W-1:0]  code_o
);
   localparam int P = CW_W - TAG_W - 1;

   logic [CW_W-1:0] spread;
   logic [P-1:0]    chk;

   // scatter data bits into non-power-of-two positions
   always_comb begin
      spread = '0;
      for (int i = 0; i < TAG_W; i++) spread[tagcmp_pkg::data_slot(i)] = tag_i[i];
   end

   // check bit b covers every position whose index has bit b set
   always_comb begin
      chk = '0;
      for (int b = 0; b < P; b++) begin
         for (int pos = 1; pos < CW_W; pos++) begin
            if (((pos >> b) & 1) == 1) chk[b] = chk[b] ^ spread[pos];
         end
      end
   end

   always_comb begin
      code_o = spread;
      for (int b = 0; b < P; b++) code_o[1 << b] = chk[b];
      code_o[0] = ^{spread, chk};
   end

endmodule

// File: rtl/tagcmp_sat_add.sv
module tagcmp_sat_add #(
   parameter int CNT_W = 2,
   parameter int CAP   = 3
) (
   input  logic [CNT_W-1:0] a_i,
   input  logic [CNT_W-1:0] b_i,
   output logic [CNT_W-1:0] s_o
);
   localparam logic [CNT_W:0] CAP_X = (CNT_W + 1)'(CAP);

   logic [CNT_W:0] full;

   assign full = {1'b0, a_i} + {1'b0, b_i};
   assign s_o  = (full > CAP_X) ? CAP_X[CNT_W-1:0] : full[CNT_W-1:0];

endmodule

// File: rtl/tagcmp_sat_tree.sv
module tagcmp_sat_tree #(
   parameter int VEC_W = 22,
   parameter int RMAX  = 2,
   parameter int CNT_W = $clog2(RMAX + 2)
) (
   input  logic [VEC_W-1:0] diff_i,
   output logic [CNT_W-1:0] count_o
);
   localparam int CAP    = RMAX + 1;
   localparam int PAIRS  = (VEC_W + 1) / 2;
   localparam int LEAVES = (PAIRS <= 1) ? 1 : (1 << $clog2(PAIRS));
   localparam int NODES  = 2 * LEAVES - 1;

   logic [CNT_W-1:0] node [NODES];

   // leaf level: one half adder per adjacent bit pair
   for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (2 * i + 1 < VEC_W) begin : g_pair
         assign node[LEAVES - 1 + i] =
            CNT_W'({diff_i[2*i] & diff_i[2*i+1], diff_i[2*i] ^ diff_i[2*i+1]});
      end else if (2 * i < VEC_W) begin : g_single
         assign node[LEAVES - 1 + i] = CNT_W'(diff_i[2*i]);
      end else begin : g_pad
         assign node[LEAVES - 1 + i] = '0;
      end
   end

   // inner levels: saturating adders, heap-indexed
   for (genvar j = 0; j < LEAVES - 1; j++) begin : g_inner
      tagcmp_sat_add #(
         .CNT_W (CNT_W),
         .CAP   (CAP)
      ) u_add (
         .a_i (node[2*j+1]),
         .b_i (node[2*j+2]),
         .s_o (node[j])
      );
   end

   assign count_o = node[0];

endmodule

// File: rtl/tagcmp_classify.sv
module tagcmp_classify #(
   parameter int TMAX  = 1,
   parameter int RMAX  = 2,
   parameter int CNT_W = $clog2(RMAX + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             valid_i,
   input  logic [CNT_W-1:0] dist_i,
   output logic             hit_o,
   output logic             corr_hit_o,
   output logic             fault_o,
   output logic             miss_o
);
   localparam logic [CNT_W-1:0] T_C = CNT_W'(TMAX);
   localparam logic [CNT_W-1:0] R_C = CNT_W'(RMAX);

   logic in_corr, in_det, live;
   logic hit_n, corr_n, fault_n, miss_n;

   assign live    = req_i & valid_i;
   assign in_corr = (dist_i <= T_C);
   assign in_det  = (dist_i > T_C) & (dist_i <= R_C);

   assign hit_n   = live & in_corr;
   assign corr_n  = live & in_corr & (dist_i != '0);
   assign fault_n = live & in_det;
   assign miss_n  = req_i & (~valid_i | (dist_i > R_C));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_o      <= 1'b0;
         corr_hit_o <= 1'b0;
         fault_o    <= 1'b0;
         miss_o     <= 1'b0;
      end else begin
         hit_o      <= hit_n;
         corr_hit_o <= corr_n;
         fault_o    <= fault_n;
         miss_o     <= miss_n;
      end
   end

   assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_o, fault_o, miss_o}));

   assert_corr_inside_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      corr_hit_o |-> hit_o);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !(hit_o || corr_hit_o || fault_o || miss_o));

   assert_fault_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> $past(valid_i));

endmodule

// File: rtl/tag_match_ecc.sv
module tag_match_ecc #(
   parameter  int TAG_W = 16,
   parameter  int TMAX  = 1,
   parameter  int RMAX  = 2,
   localparam int CW_W  = tagcmp_pkg::codeword_width(TAG_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             entry_valid_i,
   input  logic [TAG_W-1:0] probe_tag_i,
   input  logic [CW_W-1:0]  stored_code_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   output logic [CW_W-1:0]  wr_code_o,
   output logic             hit_o,
   output logic             corr_hit_o,
   output logic             fault_o,
   output logic             miss_o
);
   localparam int CNT_W = $clog2(RMAX + 2);
   localparam int CAP   = RMAX + 1;
   localparam logic [CNT_W-1:0] CAP_C = CNT_W'(CAP);

   // elaboration-time parameter checks
   if (TAG_W < 2) begin : g_bad_width
      $error("tag_match_ecc: TAG_W must be at least 2");
   end
   if (TMAX < 0 || RMAX < 1 || TMAX >= RMAX) begin : g_bad_thresholds
      $error("tag_match_ecc: need 0 <= TMAX < RMAX and RMAX >= 1");
   end

   logic [CW_W-1:0]  probe_code;
   logic [CW_W-1:0]  diff_w;
   logic [CNT_W-1:0] dist_w;

   // write-side encoder
   tagcmp_encoder #(.TAG_W(TAG_W), .CW_W(CW_W)) u_wr_enc (
      .tag_i  (wr_tag_i),
      .code_o (wr_code_o)
   );

   // lookup-side encoder
   tagcmp_encoder #(.TAG_W(TAG_W), .CW_W(CW_W)) u_probe_enc (
      .tag_i  (probe_tag_i),
      .code_o (probe_code)
   );

   assign diff_w = probe_code ^ stored_code_i;

   tagcmp_sat_tree #(.VEC_W(CW_W), .RMAX(RMAX), .CNT_W(CNT_W)) u_tree (
      .diff_i  (diff_w),
      .count_o (dist_w)
   );

   tagcmp_classify #(.TMAX(TMAX), .RMAX(RMAX), .CNT_W(CNT_W)) u_cls (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .valid_i    (entry_valid_i),
      .dist_i     (dist_w),
      .hit_o      (hit_o),
      .corr_hit_o (corr_hit_o),
      .fault_o    (fault_o),
      .miss_o     (miss_o)
   );

   assert_count_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dist_w < CAP_C) |-> (int'(dist_w) == $countones(diff_w)));

   assert_count_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dist_w == CAP_C) |-> ($countones(diff_w) >= CAP));

   assert_exact_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && entry_valid_i && diff_w == '0) |=> (hit_o && !corr_hit_o));

   assert_invalid_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !entry_valid_i) |=> (miss_o && !fault_o));

endmodule

// File: tb/test_tag_match_ecc.sv
module test_tag_match_ecc;
   localparam int TW = 16;
   localparam int CW = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          ev = 1'b0;
   logic [TW-1:0] probe = '0;
   logic [CW-1:0] stored = '0;
   logic [TW-1:0] wtag = '0;
   logic [CW-1:0] wcode;
   logic          hit, corr, fault, miss;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   tag_match_ecc i_tag_match_ecc (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_i         (req),
      .entry_valid_i (ev),
      .probe_tag_i   (probe),
      .stored_code_i (stored),
      .wr_tag_i      (wtag),
      .wr_code_o     (wcode),
      .hit_o         (hit),
      .corr_hit_o    (corr),
      .fault_o       (fault),
      .miss_o        (miss)
   );

   // codeword per R1
   function automatic logic [CW-1:0] ref_enc(input logic [TW-1:0] t);
      logic [CW-1:0] c;
      int k;
      c = '0;
      k = 0;
      for (int pos = 1; pos < CW; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            c[pos] = t[k];
            k++;
         end
      end
      for (int b = 0; b < 5; b++) begin
         logic p;
         p = 1'b0;
         for (int pos = 1; pos < CW; pos++)
            if (((pos >> b) & 1) == 1) p = p ^ c[pos];
         c[1 << b] = p;
      end
      c[0] = ^c[CW-1:1];
      return c;
   endfunction

   function automatic logic [CW-1:0] flip_mask(input int m);
      logic [CW-1:0] mk;
      mk = '0;
      while ($countones(mk) < m) mk[$urandom_range(CW-1, 0)] = 1'b1;
      return mk;
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic check4(input string rq, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {hit,corr,fault,miss} actual=%b expected=%b", rq, act, exp);
      end
   endtask

   // one lookup: drive at falling edge, sample just after the rising edge
   task automatic lookup(input logic [TW-1:0] p, input logic [CW-1:0] s, input logic v);
      int d;
      logic [3:0] exp;
      string rq;
      @(negedge clk);
      req = 1'b1; ev = v; probe = p; stored = s;
      d = $countones(ref_enc(p) ^ s);
      if (!v)          begin exp = 4'b0001; rq = "R7"; end
      else if (d == 0) begin exp = 4'b1000; rq = "R3"; end
      else if (d <= 1) begin exp = 4'b1100; rq = "R4"; end
      else if (d <= 2) begin exp = 4'b0010; rq = "R5"; end
      else             begin exp = 4'b0001; rq = "R6"; end
      @(posedge clk);
      #1;
      check4(rq, {hit, corr, fault, miss}, exp);
   endtask

   task automatic idle_check();
      @(negedge clk);
      req = 1'b0; ev = 1'b1; probe = 16'h1234; stored = ref_enc(16'h1234);
      @(posedge clk);
      #1;
      check4("R2", {hit, corr, fault, miss}, 4'b0000);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (R2): actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [TW-1:0] tags [5];
      tags[0] = 16'h0000; tags[1] = 16'hFFFF; tags[2] = 16'hA5A5;
      tags[3] = 16'h0001; tags[4] = 16'h8000;

      // R9: requests during reset leave outputs low
      req = 1'b1; ev = 1'b1; probe = 16'h00FF; stored = ref_enc(16'h00FF);
      repeat (3) @(posedge clk);
      #1;
      check4("R9", {hit, corr, fault, miss}, 4'b0000);
      stored = ref_enc(16'h00FF) ^ 22'h3;
      @(posedge clk);
      #1;
      check4("R9", {hit, corr, fault, miss}, 4'b0000);
      @(negedge clk);
      req = 1'b0;
      rst_n = 1'b1;

      // R1: exhaustive write-side encoding
      for (int t = 0; t < (1 << TW); t++) begin
         wtag = TW'(t);
         #1;
         n_chk++;
         if (wcode !== ref_enc(TW'(t))) begin
            n_bad++;
            $display("FAIL R1: tag=%h actual=%h expected=%h", t, wcode, ref_enc(TW'(t)));
         end
      end

      // R2: idle cycles after active lookups
      lookup(16'h0F0F, ref_enc(16'h0F0F), 1'b1);
      idle_check();
      lookup(16'h0F0F, ref_enc(16'h0F0F) ^ 22'h30, 1'b1);
      idle_check();

      // R3/R4/R5: every single and double flip position for corner tags
      for (int ti = 0; ti < 5; ti++) begin
         lookup(tags[ti], ref_enc(tags[ti]), 1'b1);
         for (int a = 0; a < CW; a++) begin
            lookup(tags[ti], ref_enc(tags[ti]) ^ (CW'(1) << a), 1'b1);
            for (int b = a + 1; b < CW; b++)
               lookup(tags[ti], ref_enc(tags[ti]) ^ (CW'(1) << a) ^ (CW'(1) << b), 1'b1);
         end
      end

      // R6: saturation corners, including all bits flipped
      lookup(16'h0000, ~ref_enc(16'h0000), 1'b1);
      lookup(16'hFFFF, ~ref_enc(16'hFFFF), 1'b1);
      lookup(16'h0000, ref_enc(16'hFFFF), 1'b1);
      lookup(16'hFFFF, {CW{1'b1}}, 1'b1);
      lookup(16'h0000, '0, 1'b1);
      for (int m = 3; m <= CW; m++) lookup(16'h5A5A, ref_enc(16'h5A5A) ^ flip_mask(m), 1'b1);

      // random tags with 0..5 injected flips and unrelated stored words
      for (int i = 0; i < 4000; i++) begin
         logic [TW-1:0] t;
         t = TW'($urandom());
         if (i % 7 == 6) lookup(t, ref_enc(TW'($urandom())), 1'b1);
         else            lookup(t, ref_enc(t) ^ flip_mask(i % 6), 1'b1);
         if (i % 500 == 0) idle_check();
      end

      // R7: invalid entries miss, never fault, at every distance
      for (int i = 0; i < 600; i++) begin
         logic [TW-1:0] t;
         t = TW'($urandom());
         lookup(t, ref_enc(t) ^ flip_mask(i % 5), 1'b0);
      end

      // R8: outcome exclusivity spot checks across bands
      for (int m = 0; m < 4; m++) begin
         lookup(16'h3C3C, ref_enc(16'h3C3C) ^ flip_mask(m), 1'b1);
         n_chk++;
         if (!((hit + fault + miss) == 1 && (!corr || hit))) begin
            n_bad++;
            $display("FAIL R8: actual hit=%b corr=%b fault=%b miss=%b expected exactly one outcome",
                     hit, corr, fault, miss);
         end
      end

      idle_check();
      finish_run();
   end

endmodule